// File: doc/BRIEF.md
# Round-Robin Next-Entry Selector

This block picks the next entry a scheduler should serve. A host writes two K-bit fields into registers: a one-hot field naming the entry served last, and a field of entries that are currently eligible. The block returns a K-bit field with one bit set. That bit is the first eligible entry found after the last-served one, with the search wrapping from the top position back to position 0. The host reads this field back and, once it has served that entry, writes it in as the new last-served field.

When the last-served field is all zeros, no starting point exists. For this case the block places a NOR of every last-served bit into the lowest position of its search-start vector. The search then begins at position 0 and returns the lowest eligible entry. The start vector is the last-served field rotated up by one position, so the same regular structure works for any width K. A parameter can add a registered output stage for timing.

Top module: `rr_next_sel`

## Requirements
- R1: When `cur_i` has exactly one bit set, at index c, and `mask_i` is non-zero, `next_o` sets only the bit of the first set `mask_i` bit among indices c+1, c+2, ... taken modulo K.
- R2: When `cur_i` is all zeros and `mask_i` is non-zero, `next_o` sets only the lowest-index set bit of `mask_i`.
- R3: When the only set bit of `mask_i` is the set bit of a one-hot `cur_i`, `next_o` equals `cur_i`.
- R4: When `mask_i` is all zeros, `next_o` is all zeros for any value of `cur_i`.
- R5: `next_o` never has more than one bit set and never sets a bit that is clear in `mask_i`.
- R6: With `REG_OUT`=1, `next_o` shows the result for the inputs present at the previous rising clock edge, and it reads all zeros while `rst_n` is low.
- R7: The width is set by the parameter `K` alone. The same start-vector and search structure is used for every K, with no code specific to any width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| cur_i | input | K | One-hot last-served entry, or all zeros when idle |
| mask_i | input | K | Eligible entries, bit i set when entry i may be chosen |
| next_o | output | K | One-hot next entry, or all zeros if none is eligible |

## Verification
The assertions assume that `cur_i` is one-hot or all zeros. A value with more than one bit set has no defined result, and the properties say nothing about it. The bench keeps to this rule: the directed table and the exhaustive sweep only drive the all-zero value or a single shifted one on `cur_i`, paired with every possible `mask_i` pattern at K=5. Inputs change only on falling edges, so the registered output is compared one edge later against the bench's own wrap-around search model.

// File: rtl/rr_sel_pkg.sv
package rr_sel_pkg;
  localparam int unsigned MAXW = 64;
  typedef logic [MAXW-1:0] wide_t;

  // isolate the lowest set bit of a vector
  function automatic wide_t lowest_one(input wide_t v);
    return v & (~v + wide_t'(1));
  endfunction

  // for a one-hot start vector, all positions at or above the start bit
  function automatic wide_t at_or_above(input wide_t start);
    return ~(start - wide_t'(1));
  endfunction
endpackage

// File: rtl/rr_start_gen.sv
module rr_start_gen #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] cur,
  output logic [K-1:0] start,
  output logic         idle
);
  // idle: no bit of the last-served field is set
  assign idle = ~|cur;

  // start of the search is one above the last-served entry, wrapping;
  // the idle flag is injected into the lowest position
  generate
    if (K == 1) begin : g_single
      assign start[0] = cur[0] | idle;
    end else begin : g_multi
      assign start[0] = cur[K-1] | idle;
      for (genvar i = 1; i < K; i++) begin : g_rot
        assign start[i] = cur[i-1];
      end
    end
  endgenerate
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] start,
  input  logic [K-1:0] mask,
  output logic [K-1:0] pick,
  output logic         upper_hit
);
  import rr_sel_pkg::*;

  logic [K-1:0] upper_req;
  logic [K-1:0] upper_pick;
  logic [K-1:0] wrap_pick;

  always_comb begin
    upper_req  = mask & K'(at_or_above(wide_t'(start)));
    upper_pick = K'(lowest_one(wide_t'(upper_req)));
    wrap_pick  = K'(lowest_one(wide_t'(mask)));
  end

  assign upper_hit = |upper_req;
  assign pick      = upper_hit ? upper_pick : wrap_pick;
endmodule

// File: rtl/rr_next_sel.sv
module rr_next_sel #(
  parameter int unsigned K       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] cur_i,
  input  logic [K-1:0] mask_i,
  output logic [K-1:0] next_o
);
  logic [K-1:0] search_start;
  logic         idle_in;
  logic         upper_hit;
  logic [K-1:0] nxt_comb;

  rr_start_gen #(.K(K)) u_start (
    .cur   (cur_i),
    .start (search_start),
    .idle  (idle_in)
  );

  rr_pick #(.K(K)) u_pick (
    .start     (search_start),
    .mask      (mask_i),
    .pick      (nxt_comb),
    .upper_hit (upper_hit)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [K-1:0] nxt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nxt_q <= '0;
        else        nxt_q <= nxt_comb;
      end
      assign next_o = nxt_q;
    end else begin : g_comb
      assign next_o = nxt_comb;
    end
  endgenerate
endmodule

// File: rtl/rr_next_sel_chk.sv
module rr_next_sel_chk #(
  parameter int unsigned K       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [K-1:0] cur,
  input logic [K-1:0] mask,
  input logic [K-1:0] nxt_comb,
  input logic [K-1:0] nxt_out
);
  p_onehot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nxt_comb));

  p_in_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_comb & ~mask) == '0);

  p_empty_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (nxt_comb == '0));

  p_found_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(cur) && mask != '0) |-> (nxt_comb != '0));

  p_idle_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && mask != '0) |-> (((nxt_comb - K'(1)) & mask) == '0));

  p_self_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot(cur) && mask == cur) |-> (nxt_comb == cur));

  generate
    if (REG_OUT) begin : g_lat
      p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (nxt_out == $past(nxt_comb)));
    end else begin : g_nolat
      p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_out == nxt_comb);
    end
  endgenerate
endmodule

bind rr_next_sel rr_next_sel_chk #(.K(K), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cur      (cur_i),
  .mask     (mask_i),
  .nxt_comb (nxt_comb),
  .nxt_out  (next_o)
);

// File: tb/tb_rr_next_sel.sv
module tb_rr_next_sel;
  localparam int unsigned K = 5;
  localparam int unsigned NV = 8;
  // each entry: {cur, mask, expected}
  localparam logic [3*K-1:0] VEC [NV] = '{
    {5'b00001, 5'b00110, 5'b00010},  // R1 plain step
    {5'b01000, 5'b00011, 5'b00001},  // R1 wrap past top
    {5'b10000, 5'b10100, 5'b00100},  // R1 start at top
    {5'b00000, 5'b01101, 5'b00001},  // R2 idle, bit 0 eligible
    {5'b00000, 5'b11000, 5'b01000},  // R2 idle, higher bits
    {5'b00100, 5'b00100, 5'b00100},  // R3 self only
    {5'b00010, 5'b00000, 5'b00000},  // R4 empty mask
    {5'b00000, 5'b00000, 5'b00000}   // R4 empty and idle
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [K-1:0] cur_i = '0;
  logic [K-1:0] mask_i = '0;
  logic [K-1:0] next_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 8 ns period

  rr_next_sel #(.K(K), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cur_i(cur_i), .mask_i(mask_i), .next_o(next_o)
  );

  function automatic logic [K-1:0] ref_next(input logic [K-1:0] c, input logic [K-1:0] m);
    int base;
    logic [K-1:0] r;
    r = '0;
    base = -1;
    for (int i = 0; i < K; i++) if (c[i]) base = i;
    for (int o = 0; o < K; o++) begin
      int idx;
      idx = (base < 0) ? o : (base + 1 + o) % K;
      if (r == '0 && m[idx]) r[idx] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [K-1:0] got, input logic [K-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: cur=%b mask=%b got=%b expected=%b", req, cur_i, mask_i, got, exp);
    end
  endtask

  // drive at falling edge, result registered at the next rising edge
  task automatic apply(input logic [K-1:0] c, input logic [K-1:0] m);
    @(negedge clk);
    cur_i = c;
    mask_i = m;
    @(negedge clk);
  endtask

  initial begin
    #1;
    check("R6 reset", next_o, '0);
    repeat (3) @(negedge clk);
    check("R6 held in reset", next_o, '0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][3*K-1:2*K], VEC[v][2*K-1:K]);
      check($sformatf("R1/R2/R3/R4 table %0d", v), next_o, VEC[v][K-1:0]);
    end

    // R6: output does not follow new inputs before the clock edge
    apply(5'b00001, 5'b00010);
    @(negedge clk);
    cur_i = 5'b00010;
    mask_i = 5'b10001;
    #1 check("R6 hold before edge", next_o, 5'b00010);
    @(negedge clk);
    check("R6 after edge", next_o, 5'b10000);

    // exhaustive sweep at K=5 (R1..R5, R7)
    for (int ci = -1; ci < int'(K); ci++) begin
      for (int m = 0; m < (1 << K); m++) begin
        logic [K-1:0] c;
        logic [K-1:0] e;
        c = (ci < 0) ? '0 : K'(1) << ci;
        e = ref_next(c, K'(m));
        apply(c, K'(m));
        check("R1/R2/R7 sweep", next_o, e);
        check("R5 subset", next_o & ~K'(m), '0);
        check("R5 onehot0", K'($countones(next_o) > 1), '0);
      end
    end

    // R6: asynchronous reset clears output
    apply(5'b00000, 5'b00100);
    check("R2 before reset", next_o, 5'b00100);
    #1 rst_n = 1'b0;
    #1 check("R6 async clear", next_o, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule